// File: doc/BRIEF.md
# Register File with Flag Writeback

This block is the architectural state store of a small 16-bit processor: four general-purpose data registers plus the carry and zero condition flags. Each instruction takes several timing beats. The block reads the register numbers, the write permission and the flag permissions straight from fixed bit positions of the current instruction word. It drives the two operand values to the execution logic with no register in the path.

While the third beat is high, the block keeps capturing the value to be written and the new flag values. The write data is either the low bits of the 17-bit ALU result or the memory read data. The write and the flag updates take effect on the falling edge of the third beat. In a design with one clock, that is the first clock edge at which the beat input is seen low after it was high. All registers and both flags are also brought out unregistered for debug.

Top module: `rf_core`

## Requirements
- R1: `dst_val` always equals the register numbered by instruction bits 11:10, and `src_val` the register numbered by bits 9:8, with no clock cycle of delay.
- R2: An instruction with bit 15 = 0 and bit 0 = 1 writes the low 16 bits of `alu_sum` into the destination register at commit. With bit 15 = 0 and bit 0 = 0, no register changes.
- R3: An instruction with bit 15 = 0 and bit 1 = 1 sets `zero_flag` at commit to 1 exactly when `alu_sum[15:0]` is all zero. With bit 1 = 0 the zero flag keeps its value.
- R4: An instruction with bit 15 = 0 and bit 2 = 1 sets `carry_flag` at commit to `alu_sum[16]`. With bit 2 = 0 the carry flag keeps its value.
- R5: An instruction whose bits 15:13 are 110 writes `mem_rdata` into the destination register at commit, whatever bit 0 holds.
- R6: An instruction with bits 15:14 = 10 or bits 15:13 = 111 writes no register. No instruction with bit 15 = 1 changes either flag.
- R7: The commit happens at the first rising clock edge at which `beat3` is low after having been high. It uses the instruction and data inputs seen in the last cycle in which `beat3` was high. At every other edge, no register and no flag changes.
- R8: A synchronous active-high `rst` clears all four registers and both flags to zero and cancels any pending commit.
- R9: `dbg_regs` carries register i at bits 16*i+15 down to 16*i, for i from 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Current instruction word |
| alu_sum | input | 17 | ALU result; bit 16 is the carry out |
| mem_rdata | input | 16 | Memory read data for load instructions |
| beat3 | input | 1 | High during the third timing beat |
| dst_val | output | 16 | Value of the destination-field register |
| src_val | output | 16 | Value of the source-field register |
| dbg_regs | output | 64 | All four registers packed, register 0 lowest |
| carry_flag | output | 1 | Carry flag |
| zero_flag | output | 1 | Zero flag |

## Verification
The assertions assume that `beat3` is a clean level that stays high for at least one cycle. They also assume that `instr`, `alu_sum` and `mem_rdata` change only between clock edges. The assertions in the flag and register modules compare the state after a commit with the values captured one edge earlier. They therefore rely on the capture stage being frozen while `beat3` is low. The bench drives every input just after a falling clock edge. It runs each instruction as two low beats followed by one or more high beats, and it changes the operand data inside a long third beat to exercise the last-capture rule.

// File: rtl/rf_pkg.sv
package rf_pkg;

   // Control bits derived from fixed instruction positions.
   typedef struct packed {
      logic wr_en;     // destination register written at commit
      logic from_mem;  // write data taken from memory read data
      logic z_en;      // zero flag updated at commit
      logic c_en;      // carry flag updated at commit
   } rf_ctrl_t;

   // top3: instruction bits 15:13, low3: bits 2:0
   function automatic rf_ctrl_t rf_decode_f(input logic [2:0] top3,
                                            input logic [2:0] low3);
      rf_ctrl_t c;
      c.from_mem = top3[2];
      c.z_en     = ~top3[2] & low3[1];
      c.c_en     = ~top3[2] & low3[2];
      if (!top3[2])
         c.wr_en = low3[0];
      else
         c.wr_en = (top3 == 3'b110);
      return c;
   endfunction

endpackage

// File: rtl/rf_decode.sv
module rf_decode
   import rf_pkg::*;
#(
   parameter int INSTR_W = 16,
   parameter int FIELD_W = 2,
   parameter int DST_LSB = 10,
   parameter int SRC_LSB = 8
) (
   input  logic [INSTR_W-1:0] instr,
   output rf_ctrl_t           ctrl,
   output logic [FIELD_W-1:0] dst_sel,
   output logic [FIELD_W-1:0] src_sel
);

   localparam int TOP = INSTR_W - 1;

   generate
      if (DST_LSB + FIELD_W > TOP - 2 || SRC_LSB + FIELD_W > TOP - 2) begin : g_bad_field
         $error("rf_decode: register fields overlap the class bits");
      end
      if (DST_LSB < 3 || SRC_LSB < 3) begin : g_bad_low
         $error("rf_decode: register fields overlap the enable bits");
      end
   endgenerate

   assign ctrl    = rf_decode_f(instr[TOP -: 3], instr[2:0]);
   assign dst_sel = instr[DST_LSB +: FIELD_W];
   assign src_sel = instr[SRC_LSB +: FIELD_W];

endmodule

// File: rtl/rf_stage.sv
module rf_stage
   import rf_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int FIELD_W = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               beat3,
   input  rf_ctrl_t           ctrl,
   input  logic [FIELD_W-1:0] dst_sel,
   input  logic [DATA_W:0]    alu_sum,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               commit,
   output rf_ctrl_t           p_ctrl,
   output logic [FIELD_W-1:0] p_dst,
   output logic [DATA_W-1:0]  p_data,
   output logic               p_carry,
   output logic               p_zero
);

   logic beat3_q;

   assign commit = beat3_q & ~beat3;

   always_ff @(posedge clk) begin
      if (rst) begin
         beat3_q <= 1'b0;
         p_ctrl  <= '0;
         p_dst   <= '0;
         p_data  <= '0;
         p_carry <= 1'b0;
         p_zero  <= 1'b0;
      end else begin
         beat3_q <= beat3;
         if (beat3) begin
            p_ctrl  <= ctrl;
            p_dst   <= dst_sel;
            p_data  <= ctrl.from_mem ? mem_rdata : alu_sum[DATA_W-1:0];
            p_carry <= alu_sum[DATA_W];
            p_zero  <= (alu_sum[DATA_W-1:0] == '0);
         end
      end
   end

   // R7: a commit always follows a cycle with the third beat high
   p_commit_after_beat_r7: assert property (@(posedge clk) disable iff (rst)
      commit |-> $past(beat3));

   // R7: captured data stays put outside the third beat
   p_stage_frozen_r7: assert property (@(posedge clk) disable iff (rst)
      !beat3 |=> $stable(p_data) && $stable(p_ctrl));

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
   parameter int DATA_W  = 16,
   parameter int FIELD_W = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr,
   input  logic [FIELD_W-1:0]         wr_sel,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [FIELD_W-1:0]         rd_a_sel,
   input  logic [FIELD_W-1:0]         rd_b_sel,
   output logic [DATA_W-1:0]          rd_a,
   output logic [DATA_W-1:0]          rd_b,
   output logic [(1<<FIELD_W)*DATA_W-1:0] flat
);

   localparam int NREG = 1 << FIELD_W;

   generate
      if (DATA_W < 1 || FIELD_W < 1 || NREG > 64) begin : g_bad_size
         $error("rf_bank: unsupported size");
      end
   endgenerate

   logic [DATA_W-1:0] q [NREG];

   genvar gi;
   generate
      for (gi = 0; gi < NREG; gi++) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst)
               q[gi] <= '0;
            else if (wr && wr_sel == FIELD_W'(gi))
               q[gi] <= wr_data;
         end
         assign flat[gi*DATA_W +: DATA_W] = q[gi];

         // R2/R5: the selected register takes the committed data
         p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
            wr && wr_sel == FIELD_W'(gi) |=> q[gi] == $past(wr_data));

         // R6/R7: no write strobe, no change
         p_hold_r6: assert property (@(posedge clk) disable iff (rst)
            !wr |=> $stable(q[gi]));
      end
   endgenerate

   assign rd_a = q[rd_a_sel];
   assign rd_b = q[rd_b_sel];

endmodule

// File: rtl/rf_flags.sv
module rf_flags (
   input  logic clk,
   input  logic rst,
   input  logic commit,
   input  logic z_en,
   input  logic c_en,
   input  logic z_new,
   input  logic c_new,
   output logic zero_flag,
   output logic carry_flag
);

   always_ff @(posedge clk) begin
      if (rst) begin
         zero_flag  <= 1'b0;
         carry_flag <= 1'b0;
      end else if (commit) begin
         if (z_en) zero_flag  <= z_new;
         if (c_en) carry_flag <= c_new;
      end
   end

   p_zero_update_r3: assert property (@(posedge clk) disable iff (rst)
      commit && z_en |=> zero_flag == $past(z_new));

   p_carry_update_r4: assert property (@(posedge clk) disable iff (rst)
      commit && c_en |=> carry_flag == $past(c_new));

   p_zero_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !(commit && z_en) |=> $stable(zero_flag));

   p_carry_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !(commit && c_en) |=> $stable(carry_flag));

endmodule

// File: rtl/rf_core.sv
module rf_core
   import rf_pkg::*;
#(
   parameter int INSTR_W = 16,
   parameter int DATA_W  = 16,
   parameter int FIELD_W = 2,
   parameter int DST_LSB = 10,
   parameter int SRC_LSB = 8
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic [INSTR_W-1:0]             instr,
   input  logic [DATA_W:0]                alu_sum,
   input  logic [DATA_W-1:0]              mem_rdata,
   input  logic                           beat3,
   output logic [DATA_W-1:0]              dst_val,
   output logic [DATA_W-1:0]              src_val,
   output logic [(1<<FIELD_W)*DATA_W-1:0] dbg_regs,
   output logic                           carry_flag,
   output logic                           zero_flag
);

   localparam int NREG = 1 << FIELD_W;

   generate
      if (INSTR_W < 8) begin : g_bad_instr
         $error("rf_core: instruction word too narrow");
      end
   endgenerate

   rf_ctrl_t           ctrl, p_ctrl;
   logic [FIELD_W-1:0] dst_sel, src_sel, p_dst;
   logic [DATA_W-1:0]  p_data;
   logic               commit, p_carry, p_zero;

   rf_decode #(
      .INSTR_W (INSTR_W),
      .FIELD_W (FIELD_W),
      .DST_LSB (DST_LSB),
      .SRC_LSB (SRC_LSB)
   ) u_decode (
      .instr   (instr),
      .ctrl    (ctrl),
      .dst_sel (dst_sel),
      .src_sel (src_sel)
   );

   rf_stage #(
      .DATA_W  (DATA_W),
      .FIELD_W (FIELD_W)
   ) u_stage (
      .clk       (clk),
      .rst       (rst),
      .beat3     (beat3),
      .ctrl      (ctrl),
      .dst_sel   (dst_sel),
      .alu_sum   (alu_sum),
      .mem_rdata (mem_rdata),
      .commit    (commit),
      .p_ctrl    (p_ctrl),
      .p_dst     (p_dst),
      .p_data    (p_data),
      .p_carry   (p_carry),
      .p_zero    (p_zero)
   );

   rf_bank #(
      .DATA_W  (DATA_W),
      .FIELD_W (FIELD_W)
   ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wr       (commit & p_ctrl.wr_en),
      .wr_sel   (p_dst),
      .wr_data  (p_data),
      .rd_a_sel (dst_sel),
      .rd_b_sel (src_sel),
      .rd_a     (dst_val),
      .rd_b     (src_val),
      .flat     (dbg_regs)
   );

   rf_flags u_flags (
      .clk        (clk),
      .rst        (rst),
      .commit     (commit),
      .z_en       (p_ctrl.z_en),
      .c_en       (p_ctrl.c_en),
      .z_new      (p_zero),
      .c_new      (p_carry),
      .zero_flag  (zero_flag),
      .carry_flag (carry_flag)
   );

   // R8: the cycle after reset everything reads zero
   p_reset_clear_r8: assert property (@(posedge clk)
      rst |=> dbg_regs == '0 && !zero_flag && !carry_flag);

   // R6: a class-1 instruction committed leaves flags alone
   p_no_flag_class1_r6: assert property (@(posedge clk) disable iff (rst)
      commit && p_ctrl.from_mem |=> $stable(zero_flag) && $stable(carry_flag));

   logic unused_nreg;
   assign unused_nreg = (NREG == 0);

endmodule

// File: tb/rf_core_test.sv
`timescale 1ns/1ps
module rf_core_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] instr = '0;
   logic [16:0] alu_sum = '0;
   logic [15:0] mem_rdata = '0;
   logic        beat3 = 1'b0;
   logic [15:0] dst_val, src_val;
   logic [63:0] dbg_regs;
   logic        carry_flag, zero_flag;

   rf_core uut (
      .clk        (clk),
      .rst        (rst),
      .instr      (instr),
      .alu_sum    (alu_sum),
      .mem_rdata  (mem_rdata),
      .beat3      (beat3),
      .dst_val    (dst_val),
      .src_val    (src_val),
      .dbg_regs   (dbg_regs),
      .carry_flag (carry_flag),
      .zero_flag  (zero_flag)
   );

   always #4 clk = ~clk;  // 125 MHz

   // ---------------- reference model ----------------
   int unsigned m_r [4];
   bit          m_c, m_z, m_prev_b;
   bit          pw, pc_en, pz_en, pc_v, pz_v;
   int unsigned pd, pdst;

   always @(posedge clk) begin
      if (rst) begin
         foreach (m_r[i]) m_r[i] = 0;
         m_c = 0; m_z = 0; m_prev_b = 0;
         pw = 0; pc_en = 0; pz_en = 0; pc_v = 0; pz_v = 0; pd = 0; pdst = 0;
      end else begin
         if (m_prev_b && !beat3) begin
            if (pw)    m_r[pdst] = pd;
            if (pz_en) m_z = pz_v;
            if (pc_en) m_c = pc_v;
         end
         if (beat3) begin
            pdst = instr[11:10];
            if (instr[15] == 1'b0) begin
               pw = instr[0]; pz_en = instr[1]; pc_en = instr[2];
               pd = alu_sum[15:0];
            end else begin
               pw = (instr[15:13] == 3'b110); pz_en = 0; pc_en = 0;
               pd = mem_rdata;
            end
            pc_v = alu_sum[16];
            pz_v = (alu_sum[15:0] == 16'h0);
         end
         m_prev_b = beat3;
      end
   end

   // ---------------- checking ----------------
   int n_cmp = 0, n_bad = 0;
   string tag = "R8";

   task automatic chk(string t, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk({"R1 dst ", tag}, dst_val, m_r[instr[11:10]]);
      chk({"R1 src ", tag}, src_val, m_r[instr[9:8]]);
      for (int i = 0; i < 4; i++)
         chk({"R9 reg ", tag}, dbg_regs[16*i +: 16], m_r[i]);
      chk({"R3 zero ", tag}, zero_flag, m_z);
      chk({"R4 carry ", tag}, carry_flag, m_c);
   endtask

   task automatic tick();
      @(negedge clk);
      compare_all();
   endtask

   // Runs one instruction: two low beats, then nb cycles of beat3
   task automatic run(logic [15:0] ins, logic [16:0] alu, logic [15:0] mem, int nb);
      instr = ins; alu_sum = alu; mem_rdata = mem; beat3 = 1'b0;
      tick(); tick();
      beat3 = 1'b1;
      for (int k = 0; k < nb; k++) tick();
      beat3 = 1'b0;
   endtask

   function automatic logic [15:0] mk(logic [3:0] op, int d, int s, logic [2:0] en);
      return {op, 2'(d), 2'(s), 5'b0, en};
   endfunction

   bit done = 0;

   initial begin
      #(8ns * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R8: reset state
      tag = "R8";
      rst = 1'b1; tick(); tick();
      rst = 1'b0; tick();

      // R2: load each register with ALU results via arithmetic writes
      tag = "R2";
      for (int r = 0; r < 4; r++)
         run(mk(4'b0000, r, 0, 3'b001), 17'(16'h1111 * (r + 1)), 16'hdead, 1);
      run(mk(4'b0010, 2, 1, 3'b000), 17'h0abcd, 16'h0, 1);  // bit0 clear: no write
      tick();

      // R3 / R4: flag updates and holds
      tag = "R3";
      run(mk(4'b0000, 0, 1, 3'b110), 17'h10000, 16'h0, 1); // Z=1, C=1
      tag = "R4";
      run(mk(4'b0001, 1, 1, 3'b100), 17'h00005, 16'h0, 1); // C=0, Z kept
      run(mk(4'b0011, 1, 1, 3'b010), 17'h10003, 16'h0, 1); // Z=0, C kept
      tick();

      // R5: load from memory writes regardless of bit 0
      tag = "R5";
      run(mk(4'b1100, 3, 0, 3'b000), 17'h00000, 16'hbeef, 1);
      run(mk(4'b1101, 1, 2, 3'b111), 17'h10000, 16'h5a5a, 1);
      tick();

      // R6: jumps, store, nop never write and never touch flags
      tag = "R6";
      run(mk(4'b1000, 0, 1, 3'b111), 17'h10000, 16'h1234, 1);
      run(mk(4'b1010, 2, 3, 3'b111), 17'h00000, 16'h4321, 1);
      run(mk(4'b1110, 3, 0, 3'b111), 17'h10000, 16'h7777, 1);
      run(mk(4'b1111, 1, 1, 3'b111), 17'h00000, 16'h8888, 1);
      tick();

      // R7: long third beat, data changing mid-beat; last capture wins
      tag = "R7";
      instr = mk(4'b0000, 2, 3, 3'b111); alu_sum = 17'h00001; beat3 = 1'b0;
      tick(); tick();
      beat3 = 1'b1; tick();
      alu_sum = 17'h00042; tick();
      alu_sum = 17'h10000; tick();
      beat3 = 1'b0; alu_sum = 17'h03333; tick(); tick();

      // R8: reset in the middle of a pending commit
      tag = "R8";
      instr = mk(4'b0000, 0, 0, 3'b111); alu_sum = 17'h1ffff; beat3 = 1'b1;
      tick();
      rst = 1'b1; beat3 = 1'b0; tick();
      rst = 1'b0; tick(); tick();

      // Mixed random traffic
      tag = "R7";
      for (int n = 0; n < 400; n++) begin
         logic [15:0] ins;
         logic [16:0] a;
         ins = 16'($urandom);
         a   = 17'($urandom);
         if (($urandom % 4) == 0) a[15:0] = 16'h0;
         run(ins, a, 16'($urandom), 1 + int'($urandom % 3));
      end
      tick(); tick();

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule